// File: doc/BRIEF.md
# Paged Memory Window Address Translator

This block widens a 16-bit CPU address into a 22-bit external address by way of two movable windows in the CPU's logical space. The CPU writes two 8-bit bank registers. The data bank register selects one of 256 pages of 4 Kbytes. The code bank register selects one of 256 pages of 16 Kbytes. When an access falls in an enabled window, the page number replaces the matching upper slice of the physical address. The block also raises a hit flag, which the chip-select logic uses to qualify either the data select or one of the program selects.

The data window covers CPU addresses 0x7000 to 0x7FFF. The program window covers 0x8000 to 0xBFFF. Each window has its own enable input. A 2-bit expansion-enable input can force the two highest address lines high, but only for data-window accesses. The translation is purely combinational from the current register contents. Only the register writes are clocked.

Top module: `pgwin_xlate`

## Requirements
- R1: After reset, both bank registers hold 0x00, and reading them at register offsets 0x34 and 0x35 returns 0x00.
- R2: A write happens on the rising clock edge when reg_sel and reg_wr are both high. Offset 0x34 loads the data bank and offset 0x35 loads the code bank. reg_rdata returns the addressed register at any time. A write with reg_sel low changes nothing.
- R3: When dwin_en is 1 and cpu_addr is in 0x7000..0x7FFF, data_hit is 1, phys_addr[19:12] equals the data bank, and phys_addr[11:0] equals cpu_addr[11:0].
- R4: On a data-window hit, phys_addr[20] equals xen[0] and phys_addr[21] equals xen[1].
- R5: When pwin_en is 1 and cpu_addr is in 0x8000..0xBFFF, prog_hit is 1, phys_addr[21:14] equals the code bank, and phys_addr[13:0] equals cpu_addr[13:0].
- R6: A window whose enable is 0 raises no hit, and its addresses pass through as {6'b0, cpu_addr}.
- R7: When there is no hit, phys_addr equals {6'b0, cpu_addr}. This covers the edges 0x6FFF and 0xC000.
- R8: xen has no effect on phys_addr on a program-window hit or when there is no hit.
- R9: Reads of any offset other than 0x34 and 0x35 return 0x00. Writes to such offsets leave both bank registers unchanged.
- R10: A bank written on one clock edge is used to translate the very next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe (high = write) |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (zero if unmapped) |
| cpu_addr | input | 16 | CPU logical address |
| dwin_en | input | 1 | Data window enable |
| pwin_en | input | 1 | Program window enable |
| xen | input | 2 | Expansion enable: bit 0 forces bit 20, bit 1 forces bit 21, data hits only |
| phys_addr | output | 22 | Translated physical address |
| data_hit | output | 1 | Access falls in the enabled data window |
| prog_hit | output | 1 | Access falls in the enabled program window |

## Verification
The bench tests the window edges 0x6FFF, 0x7000, 0x7FFF, 0x8000, 0xBFFF and 0xC000. A decoder with an off-by-one tag would miss or falsely hit at one of these addresses. It tries every xen pattern on data hits and drives xen high on program hits and misses. A mux that applied the expansion bits to the wrong window, or at the wrong bit positions, would show corrupted upper address lines. It clears each window enable while the address is inside that window, writes to an unmapped offset and checks both banks afterwards, and translates on the access right after a write. A design that decoded the offset loosely, or that registered the translation, would return the old page.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;

    localparam int CPU_AW   = 16;
    localparam int PHY_AW   = 22;
    localparam int PG_W     = 8;
    localparam int REG_AW   = 8;
    localparam int D_SHIFT  = 12;
    localparam int P_SHIFT  = 14;

    localparam logic [REG_AW-1:0] D_OFF = 8'h34;
    localparam logic [REG_AW-1:0] C_OFF = 8'h35;

    // Window tags: upper CPU address bits that identify each window
    localparam logic [CPU_AW-D_SHIFT-1:0] D_TAG = 4'h7;
    localparam logic [CPU_AW-P_SHIFT-1:0] P_TAG = 2'b10;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_DATA = 2'd1,
        WIN_PROG = 2'd2
    } win_e;

endpackage

// File: rtl/pgwin_regs.sv
module pgwin_regs
    import pgwin_pkg::*;
#(
    parameter int                PW    = PG_W,
    parameter int                AW    = REG_AW,
    parameter logic [AW-1:0]     DOFF  = D_OFF,
    parameter logic [AW-1:0]     COFF  = C_OFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [PW-1:0] reg_wdata,
    output logic [PW-1:0] reg_rdata,
    output logic [PW-1:0] dbank_q,
    output logic [PW-1:0] cbank_q
);

    typedef struct packed {
        logic [PW-1:0] dbank;
        logic [PW-1:0] cbank;
    } bank_t;

    bank_t st_d, st_q;
    logic  wr_en;

    assign wr_en = reg_sel && reg_wr;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (reg_addr == DOFF) begin
                st_d.dbank = reg_wdata;
            end else if (reg_addr == COFF) begin
                st_d.cbank = reg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (reg_addr == DOFF) begin
            reg_rdata = st_q.dbank;
        end else if (reg_addr == COFF) begin
            reg_rdata = st_q.cbank;
        end else begin
            reg_rdata = '0;
        end
    end

    assign dbank_q = st_q.dbank;
    assign cbank_q = st_q.cbank;

endmodule

// File: rtl/pgwin_decode.sv
module pgwin_decode
    import pgwin_pkg::*;
#(
    parameter int DS = D_SHIFT,
    parameter int PS = P_SHIFT,
    parameter int CW = CPU_AW
) (
    input  logic [CW-1:DS]      cpu_tag,
    input  logic                dwin_en,
    input  logic                pwin_en,
    output win_e                win,
    output logic                data_hit,
    output logic                prog_hit
);

    logic in_d, in_p;

    assign in_d = (cpu_tag == D_TAG);
    assign in_p = (cpu_tag[CW-1:PS] == P_TAG);

    always_comb begin
        win = WIN_NONE;
        if (dwin_en && in_d) begin
            win = WIN_DATA;
        end else if (pwin_en && in_p) begin
            win = WIN_PROG;
        end
    end

    assign data_hit = (win == WIN_DATA);
    assign prog_hit = (win == WIN_PROG);

endmodule

// File: rtl/pgwin_mux.sv
module pgwin_mux
    import pgwin_pkg::*;
#(
    parameter int CW = CPU_AW,
    parameter int XW = PHY_AW,
    parameter int PW = PG_W,
    parameter int DS = D_SHIFT,
    parameter int PS = P_SHIFT
) (
    input  win_e          win,
    input  logic [CW-1:0] cpu_addr,
    input  logic [PW-1:0] dbank,
    input  logic [PW-1:0] cbank,
    input  logic [XW-DS-PW-1:0] xen,
    output logic [XW-1:0] phys_addr
);

    localparam int D_HI = DS + PW;
    localparam int XE_W = XW - D_HI;

    logic [XE_W-1:0] force_bits;

    // One forced line per expansion-enable bit
    for (genvar i = 0; i < XE_W; i++) begin : g_force
        assign force_bits[i] = xen[i];
    end

    always_comb begin
        phys_addr           = '0;
        phys_addr[CW-1:0]   = cpu_addr;
        unique case (win)
            WIN_DATA: begin
                phys_addr[D_HI-1:DS] = dbank;
                phys_addr[XW-1:D_HI] = force_bits;
            end
            WIN_PROG: begin
                phys_addr[XW-1:PS]   = cbank;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pgwin_xlate.sv
module pgwin_xlate
    import pgwin_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_sel,
    input  logic                    reg_wr,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [PG_W-1:0]         reg_wdata,
    output logic [PG_W-1:0]         reg_rdata,
    input  logic [CPU_AW-1:0]       cpu_addr,
    input  logic                    dwin_en,
    input  logic                    pwin_en,
    input  logic [PHY_AW-D_SHIFT-PG_W-1:0] xen,
    output logic [PHY_AW-1:0]       phys_addr,
    output logic                    data_hit,
    output logic                    prog_hit
);

    logic [PG_W-1:0] dbank_q;
    logic [PG_W-1:0] cbank_q;
    win_e            win;

    pgwin_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dbank_q   (dbank_q),
        .cbank_q   (cbank_q)
    );

    pgwin_decode u_dec (
        .cpu_tag  (cpu_addr[CPU_AW-1:D_SHIFT]),
        .dwin_en  (dwin_en),
        .pwin_en  (pwin_en),
        .win      (win),
        .data_hit (data_hit),
        .prog_hit (prog_hit)
    );

    pgwin_mux u_mux (
        .win       (win),
        .cpu_addr  (cpu_addr),
        .dbank     (dbank_q),
        .cbank     (cbank_q),
        .xen       (xen),
        .phys_addr (phys_addr)
    );

endmodule

// File: rtl/pgwin_xlate_chk.sv
module pgwin_xlate_chk
    import pgwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [PG_W-1:0]   reg_wdata,
    input  logic [PG_W-1:0]   reg_rdata,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              dwin_en,
    input  logic              pwin_en,
    input  logic [1:0]        xen,
    input  logic [PHY_AW-1:0] phys_addr,
    input  logic              data_hit,
    input  logic              prog_hit,
    input  logic [PG_W-1:0]   dbank_q,
    input  logic [PG_W-1:0]   cbank_q
);

    p_dwrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == D_OFF) |=> (dbank_q == $past(reg_wdata)));

    p_cwrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == C_OFF) |=> (cbank_q == $past(reg_wdata)));

    p_dhit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dwin_en && cpu_addr[15:12] == 4'h7) |->
        (data_hit && phys_addr[19:12] == dbank_q && phys_addr[11:0] == cpu_addr[11:0]));

    p_xen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_hit |-> (phys_addr[21:20] == {xen[1], xen[0]}));

    p_phit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_hit |-> (phys_addr[21:14] == cbank_q && phys_addr[13:0] == cpu_addr[13:0]));

    p_dis_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dwin_en && !pwin_en) |-> (!data_hit && !prog_hit));

    p_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_hit && !prog_hit) |-> (phys_addr == {6'b0, cpu_addr}));

    p_unmap_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != D_OFF && reg_addr != C_OFF) |-> (reg_rdata == '0));

    p_unmap_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr != D_OFF && reg_addr != C_OFF) |=>
        (dbank_q == $past(dbank_q) && cbank_q == $past(cbank_q)));

endmodule

bind pgwin_xlate pgwin_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cpu_addr  (cpu_addr),
    .dwin_en   (dwin_en),
    .pwin_en   (pwin_en),
    .xen       (xen),
    .phys_addr (phys_addr),
    .data_hit  (data_hit),
    .prog_hit  (prog_hit),
    .dbank_q   (dbank_q),
    .cbank_q   (cbank_q)
);

// File: tb/pgwin_xlate_tb.sv
`timescale 1ns/1ps
module pgwin_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [15:0] cpu_addr = 16'h0000;
    logic        dwin_en = 1'b0;
    logic        pwin_en = 1'b0;
    logic [1:0]  xen = 2'b00;
    logic [21:0] phys_addr;
    logic        data_hit;
    logic        prog_hit;

    always #2.5 clk = ~clk;

    pgwin_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_addr(cpu_addr), .dwin_en(dwin_en), .pwin_en(pwin_en), .xen(xen),
        .phys_addr(phys_addr), .data_hit(data_hit), .prog_hit(prog_hit)
    );

    typedef struct {
        logic [21:0] phys;
        logic        dh;
        logic        ph;
        logic [7:0]  rd;
        string       req;
    } item_t;

    item_t  sbq[$];
    int     checks = 0;
    int     failures = 0;
    logic [7:0] m_dbank = 8'h00;
    logic [7:0] m_cbank = 8'h00;
    bit     drv_done = 1'b0;
    bit     finished = 1'b0;

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic sel);
        @(negedge clk);
        reg_sel = sel; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
        if (sel && a == 8'h34) m_dbank = d;
        if (sel && a == 8'h35) m_cbank = d;
    endtask

    task automatic access(input logic [15:0] ca, input logic de, input logic pe,
                          input logic [1:0] xe, input logic [7:0] ra, input string req);
        item_t it;
        @(negedge clk);
        cpu_addr = ca; dwin_en = de; pwin_en = pe; xen = xe; reg_addr = ra;
        it.dh = 1'b0; it.ph = 1'b0;
        if (de && ca >= 16'h7000 && ca <= 16'h7FFF) begin
            it.dh = 1'b1;
            it.phys = {xe[1], xe[0], m_dbank, ca[11:0]};
        end else if (pe && ca >= 16'h8000 && ca <= 16'hBFFF) begin
            it.ph = 1'b1;
            it.phys = {m_cbank, ca[13:0]};
        end else begin
            it.phys = {6'b0, ca};
        end
        it.rd = (ra == 8'h34) ? m_dbank : (ra == 8'h35) ? m_cbank : 8'h00;
        it.req = req;
        sbq.push_back(it);
    endtask

    // Monitor: compares outputs 2 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sbq.size() != 0) begin
                item_t e;
                e = sbq.pop_front();
                checks++;
                if (phys_addr !== e.phys || data_hit !== e.dh ||
                    prog_hit !== e.ph || reg_rdata !== e.rd) begin
                    failures++;
                    $display("FAIL %s: phys=%h dh=%b ph=%b rd=%h expected phys=%h dh=%b ph=%b rd=%h",
                             e.req, phys_addr, data_hit, prog_hit, reg_rdata,
                             e.phys, e.dh, e.ph, e.rd);
                end
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        access(16'h7123, 1, 1, 2'b00, 8'h34, "R1");
        access(16'h8123, 1, 1, 2'b00, 8'h35, "R1");
        // R2: writes and readback
        do_write(8'h34, 8'hA5, 1'b1);
        do_write(8'h35, 8'h3C, 1'b1);
        access(16'h0000, 1, 1, 2'b00, 8'h34, "R2");
        access(16'h0000, 1, 1, 2'b00, 8'h35, "R2");
        do_write(8'h34, 8'hFF, 1'b0);
        access(16'h0000, 1, 1, 2'b00, 8'h34, "R2_nosel");
        // R3: data window incl. edges
        access(16'h7ABC, 1, 1, 2'b00, 8'h00, "R3");
        access(16'h7000, 1, 1, 2'b00, 8'h00, "R3");
        access(16'h7FFF, 1, 1, 2'b00, 8'h00, "R3");
        // R4: expansion bits
        access(16'h7456, 1, 1, 2'b01, 8'h00, "R4");
        access(16'h7456, 1, 1, 2'b10, 8'h00, "R4");
        access(16'h7456, 1, 1, 2'b11, 8'h00, "R4");
        // R5: program window incl. edges
        access(16'h8000, 1, 1, 2'b00, 8'h00, "R5");
        access(16'hBFFF, 1, 1, 2'b00, 8'h00, "R5");
        access(16'h9234, 1, 1, 2'b00, 8'h00, "R5");
        // R6: disabled windows
        access(16'h7555, 0, 1, 2'b11, 8'h00, "R6");
        access(16'h8888, 1, 0, 2'b11, 8'h00, "R6");
        // R7: outside windows
        access(16'h6FFF, 1, 1, 2'b00, 8'h00, "R7");
        access(16'hC000, 1, 1, 2'b00, 8'h00, "R7");
        access(16'hFFFF, 1, 1, 2'b00, 8'h00, "R7");
        // R8: xen ignored on program hits and misses
        access(16'h9234, 1, 1, 2'b11, 8'h00, "R8");
        access(16'h1234, 1, 1, 2'b11, 8'h00, "R8");
        // R9: unmapped offsets
        do_write(8'h36, 8'hFF, 1'b1);
        access(16'h0000, 1, 1, 2'b00, 8'h36, "R9");
        access(16'h7001, 1, 1, 2'b00, 8'h34, "R9");
        access(16'h8001, 1, 1, 2'b00, 8'h35, "R9");
        // R10: new bank used on the next access
        do_write(8'h34, 8'h5A, 1'b1);
        access(16'h7001, 1, 1, 2'b00, 8'h00, "R10");
        do_write(8'h35, 8'hC3, 1'b1);
        access(16'hA001, 1, 1, 2'b00, 8'h00, "R10");
        drv_done = 1'b1;
        while (sbq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule